// File: doc/BRIEF.md
# Saturating Link Event Counter Bank

This block keeps eleven 16-bit tallies of link-layer events seen by a serial storage device: commands that ended with an interface CRC failure, receive-error responses broken down by direction, by data versus non-data frame and by CRC versus other cause, link-ready rising edges, and reset-signature frames that the host acknowledged. Each tally stops at its largest value and never rolls over. A link reset leaves the tallies alone. Only the synchronous power-on reset, a self-test activation strobe or a snapshot request zeroes them.

A page formatter reads the counters through a snapshot register. Raising `snap_req` for one cycle copies every tally into `snap_data` and clears the live counters on the same clock edge. An event that arrives in that same cycle is counted after the clear, so it is not lost. The combined data and non-data counters are separate tallies. They add one for any cycle in which either direction reports an error, so they are not the sum of their directional counterparts.

Top module: `lec_counter_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every counter, `snap_data` and `snap_done` become zero.
- R2: Each event strobe high at a rising edge adds one to its counters at that edge. The slot layout in `snap_data` is counter k at bits [16k+15:16k]. The slots are: 0 CRC command failure, 1 data error any direction, 2 data error device-to-host, 3 data error host-to-device, 4 non-data error any direction, 5 non-data error device-to-host, 6 non-data error host-to-device, 7 link-ready rising edges, 8 acknowledged signatures, 9 host-to-device CRC error, 10 host-to-device other error.
- R3: A counter at 65535 stays at 65535 under further events and never wraps to zero.
- R4: `selftest_clr` zeroes every counter. An event in the same cycle leaves its counter at 1.
- R5: `snap_req` copies the counter values held before that edge into `snap_data`, zeroes the counters and pulses `snap_done` for one cycle. An event in the same cycle is counted from zero.
- R6: `snap_data` keeps its value in every cycle without `snap_req`.
- R7: `link_reset` does not change any counter value.
- R8: Slot 7 adds one only on a low-to-high change of the `phy_rdy` level. Holding the level high adds nothing more.
- R9: Slot 8 counts `sig_ack` only when a `link_reset` has occurred since power-up or since the last counted `sig_ack`. Any other `sig_ack` is ignored.
- R10: Slots 1 and 4 add exactly one in a cycle where both directions report an error.
- R11: Slots 9 and 10 count independently and both add one when their strobes coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| link_reset | input | 1 | Link reset strobe; arms signature counting |
| phy_rdy | input | 1 | Link-ready level |
| sig_ack | input | 1 | Reset-signature frame sent and acknowledged good |
| ev_icrc_fail | input | 1 | Command failed with interface CRC error |
| ev_d2h_data_err | input | 1 | Error response to a device-to-host data frame |
| ev_h2d_data_err | input | 1 | Error response to a host-to-device data frame |
| ev_d2h_nd_err | input | 1 | Error response to a device-to-host non-data frame (retries included) |
| ev_h2d_nd_err | input | 1 | Error response to a host-to-device non-data frame (retries included) |
| ev_h2d_crc_err | input | 1 | Host-to-device frame rejected for CRC |
| ev_h2d_other_err | input | 1 | Host-to-device frame rejected for another cause |
| selftest_clr | input | 1 | Self-test activation: clear all counters |
| snap_req | input | 1 | Snapshot and clear request |
| snap_data | output | 176 | Snapshot of all counters, 16 bits per slot |
| snap_done | output | 1 | One-cycle pulse after a snapshot |

## Verification
The bench drives 65540 back-to-back events into one counter. A design that wraps would report a small number instead of 65535. It fires an event in the same cycle as a snapshot and in the same cycle as a self-test clear. A design that drops or double-counts that event would show 0 or an inflated value instead of exactly 1. Both data directions are struck together, and so are both host-to-device causes. A combined counter that sums its directional counters would read double, and shared cause logic would miss one of the two. The bench also holds `phy_rdy` high, sends `sig_ack` without a prior link reset, and pulses `link_reset` between events. These expose an edge detector that counts levels, a signature counter that is never disarmed, and counters that a link reset wipes.

// File: rtl/lec_pkg.sv
package lec_pkg;
    localparam int NUM_CTR  = 11;
    localparam int IX_ICRC  = 0;
    localparam int IX_DANY  = 1;
    localparam int IX_DD2H  = 2;
    localparam int IX_DH2D  = 3;
    localparam int IX_NANY  = 4;
    localparam int IX_ND2H  = 5;
    localparam int IX_NH2D  = 6;
    localparam int IX_RDY   = 7;
    localparam int IX_SIG   = 8;
    localparam int IX_HCRC  = 9;
    localparam int IX_HOTH  = 10;

    typedef struct packed {
        logic rdy;
        logic armed;
    } map_state_t;
endpackage

// File: rtl/lec_sat_ctr.sv
module lec_sat_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] MAX_VAL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        base  = clr ? '0 : cnt_q;
        cnt_d = base;
        if (inc && (base != MAX_VAL)) begin
            cnt_d = base + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == MAX_VAL && !clr) |=> (cnt_q == MAX_VAL));

    p_clear_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (cnt_q == '0));

    p_clear_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> (cnt_q == CNT_W'(1)));

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && cnt_q != MAX_VAL) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lec_event_map.sv
module lec_event_map
    import lec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               link_reset,
    input  logic               phy_rdy,
    input  logic               sig_ack,
    input  logic               ev_icrc_fail,
    input  logic               ev_d2h_data_err,
    input  logic               ev_h2d_data_err,
    input  logic               ev_d2h_nd_err,
    input  logic               ev_h2d_nd_err,
    input  logic               ev_h2d_crc_err,
    input  logic               ev_h2d_other_err,
    output logic [NUM_CTR-1:0] inc_o
);
    map_state_t st_d, st_q;

    always_comb begin
        st_d.rdy   = phy_rdy;
        st_d.armed = link_reset | (st_q.armed & ~sig_ack);

        inc_o          = '0;
        inc_o[IX_ICRC] = ev_icrc_fail;
        inc_o[IX_DD2H] = ev_d2h_data_err;
        inc_o[IX_DH2D] = ev_h2d_data_err;
        inc_o[IX_DANY] = ev_d2h_data_err | ev_h2d_data_err;
        inc_o[IX_ND2H] = ev_d2h_nd_err;
        inc_o[IX_NH2D] = ev_h2d_nd_err;
        inc_o[IX_NANY] = ev_d2h_nd_err | ev_h2d_nd_err;
        inc_o[IX_RDY]  = phy_rdy & ~st_q.rdy;
        inc_o[IX_SIG]  = sig_ack & st_q.armed;
        inc_o[IX_HCRC] = ev_h2d_crc_err;
        inc_o[IX_HOTH] = ev_h2d_other_err;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_rdy_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o[IX_RDY] |=> !inc_o[IX_RDY]);

    p_sig_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o[IX_SIG] && !link_reset) |=> !inc_o[IX_SIG]);

    p_any_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_o[IX_DD2H] || inc_o[IX_DH2D]) |-> inc_o[IX_DANY]);
endmodule

// File: rtl/lec_snap_reg.sv
module lec_snap_reg #(
    parameter int CNT_W = 16,
    parameter int N_CTR = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snap_req,
    input  logic [N_CTR*CNT_W-1:0] live_i,
    output logic [N_CTR*CNT_W-1:0] snap_o,
    output logic                   done_o
);
    localparam int VEC_W = N_CTR * CNT_W;

    typedef struct packed {
        logic [VEC_W-1:0] data;
        logic             done;
    } snap_state_t;

    snap_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = snap_req;
        if (snap_req) begin
            s_d.data = live_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap_o = s_q.data;
    assign done_o = s_q.done;

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> done_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap_o));

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap_o == $past(live_i)));
endmodule

// File: rtl/lec_counter_bank.sv
module lec_counter_bank
    import lec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     link_reset,
    input  logic                     phy_rdy,
    input  logic                     sig_ack,
    input  logic                     ev_icrc_fail,
    input  logic                     ev_d2h_data_err,
    input  logic                     ev_h2d_data_err,
    input  logic                     ev_d2h_nd_err,
    input  logic                     ev_h2d_nd_err,
    input  logic                     ev_h2d_crc_err,
    input  logic                     ev_h2d_other_err,
    input  logic                     selftest_clr,
    input  logic                     snap_req,
    output logic [NUM_CTR*CNT_W-1:0] snap_data,
    output logic                     snap_done
);
    localparam int VEC_W = NUM_CTR * CNT_W;

    logic [NUM_CTR-1:0] inc;
    logic [VEC_W-1:0]   live;
    logic               clr_all;

    assign clr_all = selftest_clr | snap_req;

    lec_event_map u_map (
        .clk              (clk),
        .rst_n            (rst_n),
        .link_reset       (link_reset),
        .phy_rdy          (phy_rdy),
        .sig_ack          (sig_ack),
        .ev_icrc_fail     (ev_icrc_fail),
        .ev_d2h_data_err  (ev_d2h_data_err),
        .ev_h2d_data_err  (ev_h2d_data_err),
        .ev_d2h_nd_err    (ev_d2h_nd_err),
        .ev_h2d_nd_err    (ev_h2d_nd_err),
        .ev_h2d_crc_err   (ev_h2d_crc_err),
        .ev_h2d_other_err (ev_h2d_other_err),
        .inc_o            (inc)
    );

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        lec_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_all),
            .inc   (inc[k]),
            .cnt_o (live[k*CNT_W +: CNT_W])
        );
    end

    lec_snap_reg #(.CNT_W(CNT_W), .N_CTR(NUM_CTR)) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .snap_req (snap_req),
        .live_i   (live),
        .snap_o   (snap_data),
        .done_o   (snap_done)
    );

    p_link_reset_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (link_reset && !clr_all && inc == '0) |=> $stable(live));

    p_done_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_done && !snap_req) |=> !snap_done);
endmodule

// File: tb/lec_counter_bank_test.sv
module lec_counter_bank_test;
    localparam int W = 16;
    localparam int N = 11;

    typedef struct packed {
        logic [6:0]  ev;
        logic [7:0]  reps;
        logic [10:0] mask;
    } vec_t;

    // ev bits: 0 icrc, 1 d2h data, 2 h2d data, 3 d2h nd, 4 h2d nd, 5 h2d crc, 6 h2d other
    localparam vec_t TBL [11] = '{
        '{7'b0000001, 8'd3, 11'b00000000001},
        '{7'b0000010, 8'd2, 11'b00000000110},
        '{7'b0000100, 8'd4, 11'b00000001010},
        '{7'b0000110, 8'd5, 11'b00000001110},
        '{7'b0001000, 8'd3, 11'b00000110000},
        '{7'b0010000, 8'd2, 11'b00001010000},
        '{7'b0011000, 8'd3, 11'b00001110000},
        '{7'b0100000, 8'd2, 11'b01000000000},
        '{7'b1000000, 8'd3, 11'b10000000000},
        '{7'b1100000, 8'd4, 11'b11000000000},
        '{7'b1111111, 8'd2, 11'b11001111111}
    };

    logic clk = 1'b0;
    logic rst_n, link_reset, phy_rdy, sig_ack, selftest_clr, snap_req;
    logic [6:0] ev;
    logic [N*W-1:0] snap_data;
    logic snap_done;
    int checks = 0;
    int errors = 0;
    logic [N*W-1:0] held;

    always #5 clk = ~clk;

    lec_counter_bank uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .link_reset       (link_reset),
        .phy_rdy          (phy_rdy),
        .sig_ack          (sig_ack),
        .ev_icrc_fail     (ev[0]),
        .ev_d2h_data_err  (ev[1]),
        .ev_h2d_data_err  (ev[2]),
        .ev_d2h_nd_err    (ev[3]),
        .ev_h2d_nd_err    (ev[4]),
        .ev_h2d_crc_err   (ev[5]),
        .ev_h2d_other_err (ev[6]),
        .selftest_clr     (selftest_clr),
        .snap_req         (snap_req),
        .snap_data        (snap_data),
        .snap_done        (snap_done)
    );

    task automatic check(input string req, input int slot, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s slot %0d: actual %0d expected %0d", req, slot, act, exp);
        end
    endtask

    function automatic logic [W-1:0] slot(input int k);
        return snap_data[k*W +: W];
    endfunction

    task automatic pulse_events(input logic [6:0] e, input int n);
        ev = e;
        repeat (n) @(negedge clk);
        ev = '0;
    endtask

    task automatic take_snap();
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; link_reset = 1'b0; phy_rdy = 1'b0; sig_ack = 1'b0;
        selftest_clr = 1'b0; snap_req = 1'b0; ev = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", -1, {31'd0, snap_done}, 32'd0);
        check("R1", -1, {31'd0, |snap_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        take_snap();
        check("R1", -1, {31'd0, |snap_data}, 32'd0);

        // R2, R10, R11: table of event patterns
        for (int i = 0; i < 11; i++) begin
            pulse_events(TBL[i].ev, int'(TBL[i].reps));
            take_snap();
            check("R5", i, {31'd0, snap_done}, 32'd1);
            for (int k = 0; k < N; k++) begin
                check(i >= 9 ? "R11" : (i == 3 || i == 6) ? "R10" : "R2", k,
                      {16'd0, slot(k)},
                      TBL[i].mask[k] ? {24'd0, TBL[i].reps} : 32'd0);
            end
        end

        // R8: ready edges only
        phy_rdy = 1'b1; repeat (5) @(negedge clk);
        phy_rdy = 1'b0; repeat (2) @(negedge clk);
        phy_rdy = 1'b1; repeat (4) @(negedge clk);
        take_snap();
        check("R8", 7, {16'd0, slot(7)}, 32'd2);

        // R9: signature needs arming by a link reset
        sig_ack = 1'b1; @(negedge clk); sig_ack = 1'b0;
        link_reset = 1'b1; @(negedge clk); link_reset = 1'b0;
        sig_ack = 1'b1; repeat (2) @(negedge clk); sig_ack = 1'b0;
        link_reset = 1'b1; @(negedge clk); link_reset = 1'b0;
        @(negedge clk);
        sig_ack = 1'b1; @(negedge clk); sig_ack = 1'b0;
        take_snap();
        check("R9", 8, {16'd0, slot(8)}, 32'd2);

        // R7: link reset keeps counts
        pulse_events(7'b0000001, 3);
        link_reset = 1'b1; repeat (2) @(negedge clk); link_reset = 1'b0;
        pulse_events(7'b0000001, 2);
        take_snap();
        check("R7", 0, {16'd0, slot(0)}, 32'd5);

        // R4: self-test clear, alone and with coincident event
        pulse_events(7'b0000101, 4);
        selftest_clr = 1'b1; @(negedge clk); selftest_clr = 1'b0;
        take_snap();
        check("R4", 0, {16'd0, slot(0)}, 32'd0);
        check("R4", 3, {16'd0, slot(3)}, 32'd0);
        pulse_events(7'b0000001, 3);
        selftest_clr = 1'b1; ev = 7'b0000001; @(negedge clk);
        selftest_clr = 1'b0; ev = '0;
        take_snap();
        check("R4", 0, {16'd0, slot(0)}, 32'd1);

        // R5: snapshot with coincident event
        pulse_events(7'b0000001, 2);
        snap_req = 1'b1; ev = 7'b0000001; @(negedge clk);
        snap_req = 1'b0; ev = '0;
        check("R5", 0, {16'd0, slot(0)}, 32'd2);
        take_snap();
        check("R5", 0, {16'd0, slot(0)}, 32'd1);

        // R6: snapshot held without request
        held = snap_data;
        pulse_events(7'b1111111, 3);
        @(negedge clk);
        check("R6", -1, {31'd0, snap_data == held}, 32'd1);
        check("R5", -1, {31'd0, snap_done}, 32'd0);
        take_snap();

        // R3: saturation
        pulse_events(7'b0000001, 65540);
        take_snap();
        check("R3", 0, {16'd0, slot(0)}, 32'd65535);
        check("R3", 1, {16'd0, slot(1)}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule